// File: doc/BRIEF.md
# Vector Memory Instruction Legality Checker

This block judges whether a decoded vector load or store may issue under the current vector configuration. It takes the element width, the register-group multiplier, the register number, the mask bit, the segment field count, the widening flag, the load/store select and the memory-width code of the instruction. It then folds five independent rules into a single verdict. The rules are configuration validity, the memory-width table, register-group alignment (including the widening limit), the mask-register overlap rule for loads, and the segment-count budget.

The verdict is registered. One cycle after the inputs are presented, `ok_o` shows whether the instruction is legal. `reason_o` shows a one-hot code naming the highest-priority rule that rejected it, or zero when it is legal. Strided and unit-stride forms share the same rules, so the checker has no input for that choice. A decode stage drives the inputs every cycle and reads the verdict in the next one.

Top module: `vmc_top`

## Requirements
- R1: When `cfg_bad_i` is 1, the instruction is illegal and `reason_o` is 5'b00001 (bit 0), whatever the other inputs are.
- R2: For loads, memory-width codes are 0 byte, 1 half, 2 word, 3 element, 4 byte unsigned, 5 half unsigned, 6 word unsigned, and 7 is illegal. Half (1, 5) is illegal at SEW code 0. Word (2, 6) is illegal at SEW codes 0 and 1. Byte and element widths are legal at every SEW. SEW codes 0..3 mean 8, 16, 32 and 64 bits. A width violation sets reason bit 1.
- R3: For stores (`is_load_i`=0), only memory-width codes 0..3 exist. Codes 4..7 are illegal with reason bit 1. Codes 0..3 follow the same SEW table as loads.
- R4: The register number must be a multiple of 2^LMUL, or of 2^(LMUL+1) when `widen_i` is 1. A violation sets reason bit 2.
- R5: A widening instruction with LMUL code 3 is illegal with reason bit 2, even at register 0.
- R6: A load with `masked_i`=1 and register 0 is illegal with reason bit 3, unless LMUL code is 0 and `force_ovl_i` is 0. Stores never raise this rule.
- R7: With field count `nf_m1_i`+1, an instruction where (`nf_m1_i`+1)·2^LMUL exceeds 8 is illegal with reason bit 4.
- R8: `reason_o` is one-hot or zero. It names only the highest-priority violated rule, in the order bit 0, 1, 2, 3, 4. `ok_o` is 1 exactly when `reason_o` is zero.
- R9: The verdict for the inputs of one cycle appears on the outputs after the next rising clock edge. While `rst` is high, both `ok_o` and `reason_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bad_i | input | 1 | Current vector configuration is invalid |
| sew_i | input | 2 | Element width code (0..3 = 8..64 bits) |
| lmul_i | input | 2 | Register-group multiplier code (group of 2^code) |
| vreg_i | input | 5 | Destination or source register number |
| masked_i | input | 1 | Operation is masked by v0 |
| nf_m1_i | input | 3 | Segment field count minus one |
| widen_i | input | 1 | Register group is doubled for widening |
| is_load_i | input | 1 | 1 = load, 0 = store |
| force_ovl_i | input | 1 | Apply the mask-overlap rule even at LMUL code 0 |
| mw_i | input | 3 | Memory-width code |
| ok_o | output | 1 | Registered verdict: instruction legal |
| reason_o | output | 5 | Registered one-hot rejection reason, zero when legal |

## Verification
The assertions assume that every input is a defined 0 or 1 at each rising edge once reset is released. They also assume that the verdict for one cycle depends only on that cycle's inputs, with no history across instructions. The stimulus changes inputs only on falling edges and drives every port for every vector. Random vectors draw each field over its full code range, including the reserved width codes and the largest field counts. Register numbers are biased toward small values, so that v0 and odd low registers appear often and the overlap and alignment rules get exercised.

// File: rtl/vmc_pkg.sv
package vmc_pkg;

    localparam int unsigned VMC_SEW_W   = 2;
    localparam int unsigned VMC_LMUL_W  = 2;
    localparam int unsigned VMC_REG_W   = 5;
    localparam int unsigned VMC_NF_W    = 3;
    localparam int unsigned VMC_MW_W    = 3;
    localparam int unsigned VMC_GROUP_LIMIT = 8;

    // Reason bit positions, index order equals priority (0 highest)
    localparam int unsigned RSN_CFG   = 0;
    localparam int unsigned RSN_WIDTH = 1;
    localparam int unsigned RSN_GROUP = 2;
    localparam int unsigned RSN_OVL   = 3;
    localparam int unsigned RSN_SEG   = 4;
    localparam int unsigned RSN_N     = 5;

    typedef enum logic [2:0] {
        ACC_BYTE = 3'd0,
        ACC_HALF = 3'd1,
        ACC_WORD = 3'd2,
        ACC_ELEM = 3'd3,
        ACC_NONE = 3'd4
    } acc_class_e;

    typedef struct packed {
        logic seg;
        logic ovl;
        logic group;
        logic width;
        logic cfg;
    } viol_t;

    // Map a memory-width code to its access class; unsupported codes -> ACC_NONE
    function automatic acc_class_e acc_class(input int unsigned code, input logic is_load);
        acc_class_e c;
        if (is_load ? (code > 6) : (code > 3)) begin
            c = ACC_NONE;
        end else begin
            case (code % 4)
                0:       c = ACC_BYTE;
                1:       c = ACC_HALF;
                2:       c = ACC_WORD;
                default: c = ACC_ELEM;
            endcase
        end
        return c;
    endfunction

    // Smallest SEW code at which an access class is permitted
    function automatic int unsigned min_sew(input acc_class_e c);
        int unsigned m;
        case (c)
            ACC_HALF: m = 1;
            ACC_WORD: m = 2;
            default:  m = 0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vmc_width_rule.sv
module vmc_width_rule
    import vmc_pkg::*;
#(
    parameter int unsigned SEW_W = VMC_SEW_W,
    parameter int unsigned MW_W  = VMC_MW_W
) (
    input  logic [SEW_W-1:0] sew,
    input  logic [MW_W-1:0]  mw,
    input  logic             is_load,
    output logic             bad
);
    acc_class_e cls;

    always_comb begin
        cls = acc_class(int'(mw), is_load);
        if (cls == ACC_NONE) begin
            bad = 1'b1;
        end else begin
            bad = int'(sew) < int'(min_sew(cls));
        end
    end
endmodule

// File: rtl/vmc_group_rule.sv
module vmc_group_rule
    import vmc_pkg::*;
#(
    parameter int unsigned REG_W  = VMC_REG_W,
    parameter int unsigned LMUL_W = VMC_LMUL_W
) (
    input  logic [REG_W-1:0]  vreg,
    input  logic [LMUL_W-1:0] lmul,
    input  logic              widen,
    output logic              bad
);
    localparam int unsigned LMUL_TOP = (1 << LMUL_W) - 1;

    int unsigned span;
    logic        widen_over;
    logic        misalign;

    always_comb begin
        span       = 1 << (int'(lmul) + int'(widen));
        widen_over = widen && (int'(lmul) == LMUL_TOP);
        misalign   = (int'(vreg) % span) != 0;
        bad        = widen_over || misalign;
    end
endmodule

// File: rtl/vmc_mask_rule.sv
module vmc_mask_rule
    import vmc_pkg::*;
#(
    parameter int unsigned REG_W  = VMC_REG_W,
    parameter int unsigned LMUL_W = VMC_LMUL_W
) (
    input  logic [REG_W-1:0]  vreg,
    input  logic [LMUL_W-1:0] lmul,
    input  logic              masked,
    input  logic              is_load,
    input  logic              force_ovl,
    output logic              bad
);
    logic hits_v0;
    logic exempt;

    always_comb begin
        hits_v0 = masked && (vreg == '0);
        exempt  = (lmul == '0) && !force_ovl;
        bad     = is_load && hits_v0 && !exempt;
    end
endmodule

// File: rtl/vmc_seg_rule.sv
module vmc_seg_rule
    import vmc_pkg::*;
#(
    parameter int unsigned LMUL_W      = VMC_LMUL_W,
    parameter int unsigned NF_W        = VMC_NF_W,
    parameter int unsigned GROUP_LIMIT = VMC_GROUP_LIMIT
) (
    input  logic [LMUL_W-1:0] lmul,
    input  logic [NF_W-1:0]   nf_m1,
    output logic              bad
);
    int unsigned regs_used;

    always_comb begin
        regs_used = (int'(nf_m1) + 1) << int'(lmul);
        bad       = regs_used > GROUP_LIMIT;
    end
endmodule

// File: rtl/vmc_top.sv
module vmc_top
    import vmc_pkg::*;
#(
    parameter int unsigned SEW_W       = VMC_SEW_W,
    parameter int unsigned LMUL_W      = VMC_LMUL_W,
    parameter int unsigned REG_W       = VMC_REG_W,
    parameter int unsigned NF_W        = VMC_NF_W,
    parameter int unsigned MW_W        = VMC_MW_W,
    parameter int unsigned GROUP_LIMIT = VMC_GROUP_LIMIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_bad_i,
    input  logic [SEW_W-1:0]  sew_i,
    input  logic [LMUL_W-1:0] lmul_i,
    input  logic [REG_W-1:0]  vreg_i,
    input  logic              masked_i,
    input  logic [NF_W-1:0]   nf_m1_i,
    input  logic              widen_i,
    input  logic              is_load_i,
    input  logic              force_ovl_i,
    input  logic [MW_W-1:0]   mw_i,
    output logic              ok_o,
    output logic [RSN_N-1:0]  reason_o
);
    viol_t            viol;
    logic [RSN_N-1:0] viol_vec;
    logic [RSN_N-1:0] first_hit;

    assign viol.cfg = cfg_bad_i;

    vmc_width_rule #(.SEW_W(SEW_W), .MW_W(MW_W)) u_width (
        .sew     (sew_i),
        .mw      (mw_i),
        .is_load (is_load_i),
        .bad     (viol.width)
    );

    vmc_group_rule #(.REG_W(REG_W), .LMUL_W(LMUL_W)) u_group (
        .vreg  (vreg_i),
        .lmul  (lmul_i),
        .widen (widen_i),
        .bad   (viol.group)
    );

    vmc_mask_rule #(.REG_W(REG_W), .LMUL_W(LMUL_W)) u_mask (
        .vreg      (vreg_i),
        .lmul      (lmul_i),
        .masked    (masked_i),
        .is_load   (is_load_i),
        .force_ovl (force_ovl_i),
        .bad       (viol.ovl)
    );

    vmc_seg_rule #(.LMUL_W(LMUL_W), .NF_W(NF_W), .GROUP_LIMIT(GROUP_LIMIT)) u_seg (
        .lmul  (lmul_i),
        .nf_m1 (nf_m1_i),
        .bad   (viol.seg)
    );

    assign viol_vec = viol;

    // Priority chain: keep a violation only if no lower-index one fired
    for (genvar i = 0; i < RSN_N; i++) begin : g_pri
        if (i == 0) begin : g_head
            assign first_hit[i] = viol_vec[i];
        end else begin : g_tail
            assign first_hit[i] = viol_vec[i] && !(|viol_vec[i-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_o     <= 1'b0;
            reason_o <= '0;
        end else begin
            ok_o     <= ~|viol_vec;
            reason_o <= first_hit;
        end
    end

    // R1: an invalid configuration wins over every other rule
    a_r1_cfg_first: assert property (@(posedge clk) disable iff (rst)
        cfg_bad_i |=> (!ok_o && reason_o == (RSN_N'(1) << RSN_CFG)));

    // R5: widening at the largest group is never accepted
    a_r5_widen_top: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bad_i && widen_i && lmul_i == '1) |=> !ok_o);

    // R6: stores never report the mask-overlap reason
    a_r6_store_no_ovl: assert property (@(posedge clk) disable iff (rst)
        !is_load_i |=> !reason_o[RSN_OVL]);

    // R8: at most one reason at a time
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reason_o));

    // R8: verdict and reason agree once out of reset
    a_r8_ok_vs_reason: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (ok_o == (reason_o == '0)));

    // R9: reset clears the outputs
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!ok_o && reason_o == '0));
endmodule

// File: tb/vmc_top_tb_top.sv
`timescale 1ns/1ps
module vmc_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_bad_i = 1'b0;
    logic [1:0] sew_i = '0;
    logic [1:0] lmul_i = '0;
    logic [4:0] vreg_i = '0;
    logic       masked_i = 1'b0;
    logic [2:0] nf_m1_i = '0;
    logic       widen_i = 1'b0;
    logic       is_load_i = 1'b1;
    logic       force_ovl_i = 1'b0;
    logic [2:0] mw_i = '0;
    logic       ok_o;
    logic [4:0] reason_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        int         stamp;
        logic       ok;
        logic [4:0] rsn;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc++;

    vmc_top dut_i (
        .clk(clk), .rst(rst), .cfg_bad_i(cfg_bad_i), .sew_i(sew_i),
        .lmul_i(lmul_i), .vreg_i(vreg_i), .masked_i(masked_i),
        .nf_m1_i(nf_m1_i), .widen_i(widen_i), .is_load_i(is_load_i),
        .force_ovl_i(force_ovl_i), .mw_i(mw_i), .ok_o(ok_o), .reason_o(reason_o)
    );

    // Reference model built from the requirement text
    task automatic model(input logic cfg, input int sew, input int lmul, input int vreg,
                         input logic msk, input int nfm1, input logic wid, input logic ld,
                         input logic frc, input int mw, output exp_t e);
        logic [4:0] v;
        int cls;
        v = '0;
        v[0] = cfg;                                           // R1
        if (ld ? mw > 6 : mw > 3) v[1] = 1'b1;                // R2 R3
        else begin
            cls = mw % 4;
            if (cls == 1 && sew < 1) v[1] = 1'b1;
            if (cls == 2 && sew < 2) v[1] = 1'b1;
        end
        if ((wid && lmul == 3) || (vreg % (1 << (lmul + int'(wid)))) != 0) v[2] = 1'b1; // R4 R5
        if (ld && msk && vreg == 0 && (frc || lmul != 0)) v[3] = 1'b1;                  // R6
        if (((nfm1 + 1) << lmul) > 8) v[4] = 1'b1;                                      // R7
        e.ok  = (v == '0);
        e.rsn = v & (~v + 5'd1);                                                        // R8
        if (v[0]) e.tag = "R1";
        else if (v[1]) e.tag = ld ? "R2" : "R3";
        else if (v[2]) e.tag = (wid && lmul == 3) ? "R5" : "R4";
        else if (v[3]) e.tag = "R6";
        else if (v[4]) e.tag = "R7";
        else e.tag = "R8";
    endtask

    task automatic drive(input logic cfg, input int sew, input int lmul, input int vreg,
                         input logic msk, input int nfm1, input logic wid, input logic ld,
                         input logic frc, input int mw);
        exp_t e;
        @(negedge clk);
        cfg_bad_i = cfg; sew_i = 2'(sew); lmul_i = 2'(lmul); vreg_i = 5'(vreg);
        masked_i = msk; nf_m1_i = 3'(nf_m1_i_cast(nfm1)); widen_i = wid; is_load_i = ld;
        force_ovl_i = frc; mw_i = 3'(mw);
        model(cfg, sew, lmul, vreg, msk, nfm1, wid, ld, frc, mw, e);
        e.stamp = cyc;
        sb.push_back(e);
    endtask

    function automatic int nf_m1_i_cast(input int x);
        return x;
    endfunction

    // Monitor: verdict is due one rising edge after the inputs (R9)
    always @(negedge clk) begin
        if (!rst && sb.size() > 0 && sb[0].stamp < cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (ok_o !== e.ok || reason_o !== e.rsn) begin
                failures++;
                $display("FAIL %s R9-latency: ok=%0b reason=%05b expected ok=%0b reason=%05b",
                         e.tag, ok_o, reason_o, e.ok, e.rsn);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: expired, actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R9 reset state
        if (ok_o !== 1'b0 || reason_o !== 5'b0) begin
            failures++;
            $display("FAIL R9 reset: ok=%0b reason=%05b expected ok=0 reason=00000", ok_o, reason_o);
        end
        rst = 1'b0;
        //    cfg sew lm reg m nf w ld f mw
        drive(1, 3, 0, 0, 0, 0, 0, 1, 0, 3);   // R1 otherwise legal
        drive(1, 0, 3, 3, 1, 7, 1, 1, 1, 7);   // R1 and R8 priority over all
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 1);   // R2 half at SEW8
        drive(0, 1, 0, 0, 0, 0, 0, 1, 0, 6);   // R2 word unsigned at SEW16
        drive(0, 2, 0, 0, 0, 0, 0, 1, 0, 2);   // R2 word at SEW32 legal
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 4);   // R2 byte unsigned at SEW8 legal
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 3);   // R2 element at SEW8 legal
        drive(0, 3, 0, 0, 0, 0, 0, 1, 0, 7);   // R2 reserved code
        drive(0, 3, 0, 0, 0, 0, 0, 0, 0, 4);   // R3 store code 4
        drive(0, 3, 0, 0, 0, 0, 0, 0, 0, 3);   // R3 store element legal
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);   // R3 store half at SEW8
        drive(0, 3, 1, 2, 0, 0, 0, 1, 0, 3);   // R4 aligned
        drive(0, 3, 1, 3, 0, 0, 0, 1, 0, 3);   // R4 misaligned
        drive(0, 3, 1, 2, 0, 0, 1, 1, 0, 3);   // R4 widening misaligned
        drive(0, 3, 1, 4, 0, 0, 1, 1, 0, 3);   // R4 widening aligned
        drive(0, 3, 3, 0, 0, 0, 1, 1, 0, 3);   // R5 widen at group 8
        drive(0, 3, 0, 0, 1, 0, 0, 1, 0, 3);   // R6 exempt at LMUL 0
        drive(0, 3, 0, 0, 1, 0, 0, 1, 1, 3);   // R6 forced
        drive(0, 3, 1, 0, 1, 0, 0, 1, 0, 3);   // R6 LMUL 1
        drive(0, 3, 1, 0, 1, 0, 0, 0, 1, 3);   // R6 store exempt
        drive(0, 3, 2, 0, 0, 1, 0, 1, 0, 3);   // R7 exactly 8
        drive(0, 3, 1, 0, 0, 4, 0, 1, 0, 3);   // R7 ten registers
        drive(0, 3, 0, 0, 0, 7, 0, 1, 0, 3);   // R7 eight fields at LMUL 0
        drive(0, 0, 1, 1, 0, 0, 0, 1, 0, 1);   // R8 width beats group
        drive(0, 3, 1, 1, 1, 7, 0, 1, 0, 3);   // R8 group beats seg
        drive(0, 3, 1, 0, 1, 7, 0, 1, 0, 3);   // R8 overlap beats seg
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = ($urandom % 4 == 0) ? int'($urandom % 32) : int'($urandom % 4);
            drive(($urandom % 8) == 0, $urandom % 4, $urandom % 4, r, $urandom % 2,
                  $urandom % 8, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 8);
        end
        while (sb.size() > 0) @(negedge clk);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule